// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Register Interface

This block lets an 8-bit host processor reach a bank of 256 byte-wide registers over a bus whose address and data share the same eight lines. At the start of a cycle the host drives an address and pulses an active-high latch enable; the falling edge of that enable captures the address. The host then asserts an active-low chip select and moves data under strobe control. Raising chip select ends the cycle and releases the shared lines.

A static mode pin selects one of two strobe conventions. In split mode, two separate active-low strobes qualify reads and writes. In combined mode, a single active-low strobe qualifies every transfer and a second line gives the direction. All host signals are resynchronized into a fast system clock through two flip-flops, and edges are detected on the resynchronized copies. Core logic sees every committed write as a one-cycle pulse carrying its address and data, and reads any location through its own read port. The register contents have no reset, so they survive a reset of the interface.

Top module: `hbus_regif`

## Requirements
- R1: With `mode_sel` = 0, a read is qualified by `rd_n` low and a write by `wr_n` low. During a qualified read, `ad_out` carries the byte stored at the latched address.
- R2: With `mode_sel` = 1, `rd_n` low is the only strobe. When the strobe is active, `wr_n` = 1 selects a read and `wr_n` = 0 selects a write.
- R3: The address is taken from `ad_in` on the falling edge of `ale`. It is held unchanged until the next falling edge, so data placed on `ad_in` afterwards does not move it.
- R4: All 256 locations, 0x00 through 0xFF, can be written from the bus. A written byte is visible both on a bus read and on `core_rdata` for the same `core_raddr`.
- R5: `ad_oe` is high only while `cs_n` is low and a read is qualified. It returns low after `cs_n` rises, within 4 clock cycles of the pin change.
- R6: A write commits when its qualifying strobe deasserts. `reg_wr_pulse` is high for exactly one clock, within 4 clock cycles of the strobe edge, with `reg_wr_addr` equal to the latched address and `reg_wr_data` equal to the data on `ad_in`.
- R7: Only the first write inside one chip-select low period is committed. Further write strobes before `cs_n` rises are ignored.
- R8: A write strobe that deasserts at the same moment as `cs_n` rises is still committed.
- R9: Asserting `rst_n` does not change any stored register byte.
- R10: A strobe given while `cs_n` is high causes neither a write nor an output enable.
- R11: Out of reset, `ad_oe` and `reg_wr_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host bus |
| rst_n | input | 1 | Asynchronous active-low reset of the interface logic |
| mode_sel | input | 1 | Static strobe convention: 0 split, 1 combined |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Active-high address latch enable |
| rd_n | input | 1 | Read strobe (mode 0) or common strobe (mode 1), active low |
| wr_n | input | 1 | Write strobe (mode 0) or direction, high = read (mode 1) |
| ad_in | input | 8 | Shared address/data lines as seen from the pads |
| ad_out | output | 8 | Read data toward the pads |
| ad_oe | output | 1 | Pad output enable for the shared lines |
| core_raddr | input | 8 | Core-side read address |
| core_rdata | output | 8 | Core-side read data |
| reg_wr_pulse | output | 1 | One-cycle write commit strobe to the core |
| reg_wr_addr | output | 8 | Address of the committed write |
| reg_wr_data | output | 8 | Data of the committed write |

## Verification
Two events can fall in the same sampled cycle: the end of a write strobe and the end of the chip-select period. When that happens, the commit and the cycle reset compete. The bench provokes this by releasing the strobe and `cs_n` in one step, in both modes. It judges the result by a single write pulse with the right address and data, followed by a read-back of the stored byte. The other pairing is a second write strobe inside a cycle whose first write already committed. Here the bench expects the pulse count to stay the same and the first byte to remain stored.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BUS_W_DEF  = 8;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_DSTRB = 1'b1
  } hbus_mode_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_cycle.sv
module hbus_cycle
  import hbus_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hbus_mode_e       mode,
  input  logic             s_cs_n,
  input  logic             s_ale,
  input  logic             s_rd_n,
  input  logic             s_wr_n,
  input  logic [BUS_W-1:0] s_ad,
  output logic [BUS_W-1:0] addr_q,
  output logic             rd_en,
  output logic             wr_en,
  output logic             ale_fall
);
  logic             p_ale, p_wr_act, p_cs_n, done;
  logic             n_done;
  logic [BUS_W-1:0] n_addr;
  logic             rd_act, wr_act;

  // strobe decode per convention
  always_comb begin
    if (mode == MODE_SPLIT) begin
      rd_act = ~s_rd_n;
      wr_act = ~s_wr_n;
    end else begin
      rd_act = ~s_rd_n &  s_wr_n;
      wr_act = ~s_rd_n & ~s_wr_n;
    end
  end

  // next state
  always_comb begin
    ale_fall = p_ale & ~s_ale;
    wr_en    = p_wr_act & ~wr_act & ~p_cs_n & ~done;
    rd_en    = ~s_cs_n & rd_act;
    n_done   = s_cs_n ? 1'b0 : (done | wr_en);
    n_addr   = ale_fall ? s_ad : addr_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ale    <= 1'b0;
      p_wr_act <= 1'b0;
      p_cs_n   <= 1'b1;
      done     <= 1'b0;
      addr_q   <= '0;
    end else begin
      p_ale    <= s_ale;
      p_wr_act <= wr_act;
      p_cs_n   <= s_cs_n;
      done     <= n_done;
      addr_q   <= n_addr;
    end
  end
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // contents deliberately carry no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_pkg::*;
#(
  parameter int BUS_W = BUS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             cs_n,
  input  logic             ale,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] core_raddr,
  output logic [BUS_W-1:0] core_rdata,
  output logic             reg_wr_pulse,
  output logic [BUS_W-1:0] reg_wr_addr,
  output logic [BUS_W-1:0] reg_wr_data
);
  localparam int CTL_W = 4;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CTL_W-1:0] s_ctl;
  logic             s_cs_n, s_ale, s_rd_n, s_wr_n;
  logic [BUS_W-1:0] s_ad;
  logic [BUS_W-1:0] addr_q;
  logic             rd_en, wr_en, ale_fall;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_sync_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .d({cs_n, ale, rd_n, wr_n}), .q(s_ctl)
  );
  assign {s_cs_n, s_ale, s_rd_n, s_wr_n} = s_ctl;

  hbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
    .clk(clk), .rst_n(rst_int_n), .d(ad_in), .q(s_ad)
  );

  hbus_cycle #(.BUS_W(BUS_W)) u_cyc (
    .clk(clk), .rst_n(rst_int_n), .mode(hbus_mode_e'(mode_sel)),
    .s_cs_n(s_cs_n), .s_ale(s_ale), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
    .s_ad(s_ad), .addr_q(addr_q), .rd_en(rd_en), .wr_en(wr_en),
    .ale_fall(ale_fall)
  );

  hbus_regfile #(.AW(BUS_W), .DW(BUS_W)) u_rf (
    .clk(clk), .we(wr_en), .waddr(addr_q), .wdata(s_ad),
    .raddr_a(addr_q), .rdata_a(ad_out),
    .raddr_b(core_raddr), .rdata_b(core_rdata)
  );

  assign ad_oe        = rd_en;
  assign reg_wr_pulse = wr_en;
  assign reg_wr_addr  = addr_q;
  assign reg_wr_data  = s_ad;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_sel,
  input logic             cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             ad_oe,
  input logic             reg_wr_pulse,
  input logic [BUS_W-1:0] reg_wr_addr,
  input logic             s_cs_n,
  input logic             ale_fall
);
  logic [1:0] wr_in_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_in_cyc <= '0;
    else if (s_cs_n) wr_in_cyc <= '0;
    else if (reg_wr_pulse && wr_in_cyc != 2'd3) wr_in_cyc <= wr_in_cyc + 2'd1;
  end

  p_oe_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !$past(cs_n, 2));

  p_split_read_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !mode_sel) |-> !$past(rd_n, 2));

  p_dir_high_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && mode_sel) |-> ($past(wr_n, 2) && !$past(rd_n, 2)));

  p_wr_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_pulse |=> !reg_wr_pulse);

  p_wr_once_per_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_pulse |-> (wr_in_cyc == 2'd0));

  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale_fall) |-> $stable(reg_wr_addr));
endmodule

bind hbus_regif hbus_regif_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .reg_wr_pulse(reg_wr_pulse),
  .reg_wr_addr(reg_wr_addr), .s_cs_n(s_cs_n), .ale_fall(ale_fall)
);

// File: tb/sim_hbus_regif.sv
`timescale 1ns/1ps
module sim_hbus_regif;
  logic       clk = 1'b0;
  logic       rst_n, mode_sel, cs_n, ale, rd_n, wr_n;
  logic [7:0] ad_in, ad_out, core_raddr, core_rdata, reg_wr_addr, reg_wr_data;
  logic       ad_oe, reg_wr_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_cnt = 0;
  int wide_pulse = 0;
  int cyc = 0;
  logic [7:0] last_addr, last_data;
  logic [7:0] model [256];
  logic       prev_pulse = 1'b0;

  always #2.5 clk = ~clk;

  hbus_regif u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .core_raddr(core_raddr), .core_rdata(core_rdata),
    .reg_wr_pulse(reg_wr_pulse), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data)
  );

  // observe write commits between edges
  always @(negedge clk) begin
    if (reg_wr_pulse) begin
      pulse_cnt++;
      last_addr = reg_wr_addr;
      last_data = reg_wr_data;
      if (prev_pulse) wide_pulse++;
    end
    prev_pulse = reg_wr_pulse;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(input logic [7:0] a);
    return model[a];
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic latch_addr(input logic [7:0] a);
    ad_in = a; ale = 1'b1; settle();
    ale = 1'b0; settle();
  endtask

  // join_cs: release strobe and chip select in the same step
  task automatic bus_write(input bit md, input logic [7:0] a, input logic [7:0] d, input bit join_cs);
    mode_sel = md;
    latch_addr(a);
    ad_in = d; cs_n = 1'b0;
    if (!md) begin
      wr_n = 1'b0; settle();
      if (join_cs) begin wr_n = 1'b1; cs_n = 1'b1; settle(); end
      else begin wr_n = 1'b1; settle(); cs_n = 1'b1; settle(); end
    end else begin
      wr_n = 1'b0; settle();
      rd_n = 1'b0; settle();
      if (join_cs) begin rd_n = 1'b1; cs_n = 1'b1; settle(); wr_n = 1'b1; end
      else begin rd_n = 1'b1; settle(); wr_n = 1'b1; cs_n = 1'b1; settle(); end
    end
  endtask

  task automatic bus_read(input bit md, input logic [7:0] a,
                          output logic oe_on, output logic [7:0] dat, output logic oe_off);
    mode_sel = md;
    latch_addr(a);
    cs_n = 1'b0;
    wr_n = 1'b1; rd_n = 1'b0; settle();
    oe_on = ad_oe; dat = ad_out;
    rd_n = 1'b1; cs_n = 1'b1; settle();
    oe_off = ad_oe;
  endtask

  task automatic write_and_verify(input bit wm, input bit rm, input logic [7:0] a,
                                  input logic [7:0] d, input bit join_cs);
    int pre;
    logic oe_on, oe_off;
    logic [7:0] dat;
    pre = pulse_cnt;
    bus_write(wm, a, d, join_cs);
    model[a] = d;
    if (join_cs) chk(pulse_cnt == pre + 1, "R8 commit on joint release", pulse_cnt - pre, 1);
    else         chk(pulse_cnt == pre + 1, "R6 one commit per write", pulse_cnt - pre, 1);
    chk(last_addr == a, "R3 latched address at commit", last_addr, a);
    chk(last_data == d, "R6 commit data", last_data, d);
    bus_read(rm, a, oe_on, dat, oe_off);
    chk(oe_on == 1'b1, "R5 oe during read", oe_on, 1);
    if (!rm) chk(dat == expect_byte(a), "R1 split read data", dat, expect_byte(a));
    else     chk(dat == expect_byte(a), "R2 combined read data", dat, expect_byte(a));
    chk(oe_off == 1'b0, "R5 oe off after cs high", oe_off, 0);
    core_raddr = a; #1;
    chk(core_rdata == expect_byte(a), "R4 core port read", core_rdata, expect_byte(a));
  endtask

  initial begin
    int pre;
    logic oe_on, oe_off;
    logic [7:0] dat;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; mode_sel = 1'b0; cs_n = 1'b1; ale = 1'b0;
    rd_n = 1'b1; wr_n = 1'b1; ad_in = '0; core_raddr = '0;
    repeat (5) @(posedge clk);
    #1;
    chk(ad_oe == 1'b0, "R11 oe low in reset", ad_oe, 0);
    chk(reg_wr_pulse == 1'b0, "R11 no write in reset", reg_wr_pulse, 0);
    rst_n = 1'b1; settle();
    chk(ad_oe == 1'b0 && pulse_cnt == 0, "R11 idle after reset", pulse_cnt, 0);

    // R4 address corners, both modes
    write_and_verify(1'b0, 1'b1, 8'h00, 8'hA5, 1'b0);
    write_and_verify(1'b1, 1'b0, 8'hFF, 8'h3C, 1'b0);

    // R8 strobe release coincident with chip-select release
    write_and_verify(1'b0, 1'b0, 8'h41, 8'h96, 1'b1);
    write_and_verify(1'b1, 1'b1, 8'h42, 8'h69, 1'b1);

    // R7 second write strobe inside one chip-select period
    mode_sel = 1'b0;
    latch_addr(8'h55);
    pre = pulse_cnt;
    ad_in = 8'h11; cs_n = 1'b0;
    wr_n = 1'b0; settle(); wr_n = 1'b1; settle();
    ad_in = 8'h22;
    wr_n = 1'b0; settle(); wr_n = 1'b1; settle();
    cs_n = 1'b1; settle();
    model[8'h55] = 8'h11;
    chk(pulse_cnt == pre + 1, "R7 only first write commits", pulse_cnt - pre, 1);
    core_raddr = 8'h55; #1;
    chk(core_rdata == expect_byte(8'h55), "R7 first byte kept", core_rdata, expect_byte(8'h55));

    // R10 strobes with chip select high
    pre = pulse_cnt;
    latch_addr(8'h55);
    ad_in = 8'hEE;
    wr_n = 1'b0; settle(); wr_n = 1'b1; settle();
    rd_n = 1'b0; settle();
    chk(ad_oe == 1'b0, "R10 no oe without cs", ad_oe, 0);
    rd_n = 1'b1; settle();
    chk(pulse_cnt == pre, "R10 no commit without cs", pulse_cnt - pre, 0);
    core_raddr = 8'h55; #1;
    chk(core_rdata == expect_byte(8'h55), "R10 byte unchanged", core_rdata, expect_byte(8'h55));

    // R2 combined mode: strobe low with direction low is not a read
    mode_sel = 1'b1;
    latch_addr(8'h55);
    pre = pulse_cnt;
    ad_in = 8'h77; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; settle();
    chk(ad_oe == 1'b0, "R2 write direction gives no oe", ad_oe, 0);
    rd_n = 1'b1; settle(); wr_n = 1'b1; cs_n = 1'b1; settle();
    model[8'h55] = 8'h77;
    chk(pulse_cnt == pre + 1, "R2 direction low commits write", pulse_cnt - pre, 1);

    // R1 split mode: write strobe alone gives no oe
    mode_sel = 1'b0;
    latch_addr(8'h55);
    pre = pulse_cnt;
    ad_in = 8'h5A; cs_n = 1'b0; wr_n = 1'b0; settle();
    chk(ad_oe == 1'b0, "R1 write strobe gives no oe", ad_oe, 0);
    wr_n = 1'b1; settle(); cs_n = 1'b1; settle();
    model[8'h55] = 8'h5A;
    chk(pulse_cnt == pre + 1, "R1 write strobe commits", pulse_cnt - pre, 1);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, d;
      bit wm, rm;
      a = 8'($urandom); d = 8'($urandom);
      wm = 1'($urandom); rm = 1'($urandom);
      write_and_verify(wm, rm, a, d, 1'($urandom % 4 == 0));
    end

    // R9 reset keeps contents
    rst_n = 1'b0; repeat (3) @(posedge clk); #1;
    rst_n = 1'b1; settle();
    core_raddr = 8'h00; #1;
    chk(core_rdata == expect_byte(8'h00), "R9 byte kept over reset", core_rdata, expect_byte(8'h00));
    core_raddr = 8'hFF; #1;
    chk(core_rdata == expect_byte(8'hFF), "R9 byte kept over reset", core_rdata, expect_byte(8'hFF));
    bus_read(1'b0, 8'h55, oe_on, dat, oe_off);
    chk(dat == expect_byte(8'h55), "R9 bus read after reset", dat, expect_byte(8'h55));

    chk(wide_pulse == 0, "R6 pulse one clock wide", wide_pulse, 0);
    summary();
    $finish;
  end
endmodule